// File: doc/BRIEF.md
# Serial flash command controller

This block sits on a simple register port and drives up to four serial NOR flash devices through one shared SPI bus (one serial clock, one data-out line, one data-in line and one active-low chip select per bank). A single shift engine serves two modes that are picked by a bit in the control register.

In raw mode the host first fills a 32-bit transmit word. It then writes a command word that names the bank, the number of bytes to send (1 to 4) and the number of bytes to read back (0 to 3), and sets the send bit. In fixed-command mode the host writes a command word that asks for exactly one of two built-in operations: fetch the flash status byte (opcode 0x05, one byte back) or set the flash write-enable latch (opcode 0x06, nothing back). In that mode the controller keeps a per-bank copy of each device's write-enable latch in its status register. Completion is reported through a sticky flag that software clears by writing zero. The same clear-by-zero rule applies to two error flags and a write-complete flag.

The register map, with the 3-bit address given first:
- 0, control: bit 0 selects raw mode (1) or fixed-command mode (0); bits 7:4 hold the half-period count N.
- 1, command (write only): bits 1:0 bank, bit 2 send, bits 5:4 transmit length minus one, bits 7:6 receive length, bit 8 status fetch, bit 9 write enable.
- 2, transmit word.
- 3, receive word (read only).
- 4, status: bit 0 done, bit 1 busy-reject error, bit 2 illegal-command error, bit 3 write complete, bits 11:8 per-bank write-enable copy, bits 31:24 last flash status byte.

The engine states are IDLE, SETUP, HIGH, LOW and HOLD. The transitions are:
- IDLE goes to SETUP on an accepted start.
- SETUP goes to HIGH on a half tick (first rising edge).
- HIGH goes to LOW on a half tick, or to HOLD when the falling edge just made was the last bit.
- LOW goes to HIGH on a half tick.
- HOLD goes to IDLE on its second half tick, releasing the chip select.

Top module: `serial_flash_ctrl`

## Requirements
- R1: After reset the control register reads 0x20 (fixed-command mode, N=2), status and receive words read 0, all chip selects are high and the serial clock is low.
- R2: During a transfer exactly the chip select of the bank in command bits 1:0 is low, and no chip select is low while the engine is idle.
- R3: A raw-mode send transmits the low L bytes of the transmit word (L = command bits 5:4 plus 1). Byte L-1 goes first, each byte most significant bit first, in SPI mode 0 (clock idles low, data sampled on the rising edge).
- R4: A raw-mode transfer reads R bytes (R = command bits 7:6) after the transmitted ones. Received byte j lands in receive bits [23-8j:16-8j], and all other bits read 0.
- R5: Status bit 0 sets when a transfer ends and stays set until a status write with bit 0 at 0. Writing 1 to any sticky flag leaves it unchanged.
- R6: A fixed-mode status fetch (command bit 8) sends 0x05, reads one byte and places it in status bits 31:24. Status bit 3 sets when bit 0 of that byte (write in progress) is 0, and is cleared by writing 0.
- R7: A fixed-mode write enable (command bit 9) sends only 0x06 and sets status bit 8+bank. A later status fetch of that bank copies bit 1 of the flash status byte into status bit 8+bank.
- R8: A command with any request bit that arrives while a transfer runs is ignored: the running transfer and its bank are unchanged, no second transfer starts, and status bit 1 sets.
- R9: A request that does not match the mode starts nothing and sets status bit 2. Mismatches are: send bit in fixed mode, either fixed bit in raw mode, or both fixed bits at once.
- R10: The serial clock period is 2N system clocks, with N from control bits 7:4; N=0 acts as N=1.
- R11: Chip select stays low through the transmit and receive bytes and rises exactly one serial clock period (2N system clocks) after the last falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | NUM_BANKS | Active-low chip selects, one per bank |

## Verification
Register writes take effect at the clock edge that samples the strobe, so the bench reads them back on the following cycle. For a transfer of K bits started at edge 0, the last falling serial edge is 2KN cycles later and chip select rises 2N cycles after that. The done flag then shows one cycle after chip select rises, which is 2N(K+1)+1 cycles in all. The bench therefore polls the done flag and never waits a fixed time. It measures the serial clock period and the chip-select hold in nanoseconds against 16N ns (8 ns clock), using the edge times its flash responder records. Error flags are read on the cycle right after the offending command write.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CMD  = 3'd1;
    localparam logic [2:0] ADDR_TXD  = 3'd2;
    localparam logic [2:0] ADDR_RXD  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;

    localparam int MAX_TX_BYTES = 4;
    localparam int MAX_RX_BYTES = 3;
    localparam int WE_SHIFT     = 8;

    typedef enum logic [1:0] {OPK_RAW, OPK_RDSR, OPK_WREN} op_kind_t;
    typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD} eng_state_t;

    typedef struct packed {
        logic [1:0]  bank;
        logic [2:0]  tx_bytes;
        logic [1:0]  rx_bytes;
        logic [31:0] tx_word;
    } xfer_req_t;
endpackage

// File: rtl/sfc_clkdiv.sv
module sfc_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             half_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;

    always_comb begin
        eff       = (half_div == '0) ? DIV_W'(1) : half_div;
        half_tick = run && (cnt == eff - DIV_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || half_tick) cnt <= '0;
        else                       cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  xfer_req_t            req,
    input  logic                 half_tick,
    input  logic                 spi_miso,
    output logic                 busy,
    output logic                 done,
    output logic [23:0]          rx_word,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    output logic [NUM_BANKS-1:0] spi_cs_n
);
    localparam int TXW   = 8 * MAX_TX_BYTES;
    localparam int RXW   = 8 * MAX_RX_BYTES;
    localparam int BIT_W = $clog2(TXW + RXW + 1);

    eng_state_t       state, nxt;
    logic [TXW-1:0]   tx_sh;
    logic [RXW-1:0]   rx_sh;
    logic [BIT_W-1:0] bit_cnt, total_bits, rx_first;
    logic [1:0]       rx_len_q;
    logic             hold_q;
    logic             last_bit;

    assign busy     = (state != ST_IDLE);
    assign spi_mosi = tx_sh[TXW-1];
    assign last_bit = (bit_cnt == total_bits - BIT_W'(1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)     nxt = ST_SETUP;
            ST_SETUP: if (half_tick) nxt = ST_HIGH;
            ST_HIGH:  if (half_tick) nxt = last_bit ? ST_HOLD : ST_LOW;
            ST_LOW:   if (half_tick) nxt = ST_HIGH;
            ST_HOLD:  if (half_tick && hold_q) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh      <= '0;
            rx_sh      <= '0;
            bit_cnt    <= '0;
            total_bits <= '0;
            rx_first   <= '0;
            rx_len_q   <= '0;
            hold_q     <= 1'b0;
            spi_sclk   <= 1'b0;
            spi_cs_n   <= '1;
            done       <= 1'b0;
            rx_word    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        tx_sh      <= req.tx_word << (8 * (MAX_TX_BYTES - int'(req.tx_bytes)));
                        rx_sh      <= '0;
                        bit_cnt    <= '0;
                        total_bits <= BIT_W'(8 * (int'(req.tx_bytes) + int'(req.rx_bytes)));
                        rx_first   <= BIT_W'(8 * int'(req.tx_bytes));
                        rx_len_q   <= req.rx_bytes;
                        hold_q     <= 1'b0;
                        for (int i = 0; i < NUM_BANKS; i++)
                            spi_cs_n[i] <= (int'(req.bank) != i);
                    end
                end
                ST_SETUP, ST_LOW: begin
                    if (half_tick) begin
                        spi_sclk <= 1'b1;
                        if (bit_cnt >= rx_first)
                            rx_sh <= {rx_sh[RXW-2:0], spi_miso};
                    end
                end
                ST_HIGH: begin
                    if (half_tick) begin
                        spi_sclk <= 1'b0;
                        bit_cnt  <= bit_cnt + BIT_W'(1);
                        tx_sh    <= {tx_sh[TXW-2:0], 1'b0};
                    end
                end
                ST_HOLD: begin
                    if (half_tick) begin
                        hold_q <= 1'b1;
                        if (hold_q) begin
                            spi_cs_n <= '1;
                            done     <= 1'b1;
                            rx_word  <= rx_sh << (8 * (MAX_RX_BYTES - int'(rx_len_q)));
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/serial_flash_ctrl.sv
module serial_flash_ctrl
    import sfc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DIV_W     = 4,
    parameter int DIV_RESET = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic [NUM_BANKS-1:0] spi_cs_n
);
    localparam int DIV_LSB = 4;

    logic                 ctrl_raw;
    logic [DIV_W-1:0]     ctrl_div;
    logic [31:0]          tx_reg;
    logic [23:0]          rx_reg;
    logic                 flag_done, flag_err_busy, flag_err_cmd, flag_wcf;
    logic [NUM_BANKS-1:0] we_copy;
    logic [7:0]           stat_byte;
    op_kind_t             op_kind;
    logic [1:0]           op_bank;

    logic      cmd_wr, stat_wr, cmd_req, illegal, start, reject_busy, reject_cmd;
    logic      f_send, f_rd, f_we;
    xfer_req_t req;
    logic      eng_busy, eng_done, half_tick;
    logic [23:0] eng_rx;

    // command decode
    always_comb begin
        cmd_wr  = reg_wr && (reg_addr == ADDR_CMD);
        stat_wr = reg_wr && (reg_addr == ADDR_STAT);
        f_send  = reg_wdata[2];
        f_rd    = reg_wdata[8];
        f_we    = reg_wdata[9];
        cmd_req = cmd_wr && (f_send || f_rd || f_we);
        illegal = (ctrl_raw ? (f_rd || f_we) : (f_send || (f_rd && f_we)))
                  || (int'(reg_wdata[1:0]) >= NUM_BANKS);
        start       = cmd_req && !eng_busy && !illegal;
        reject_busy = cmd_req && eng_busy;
        reject_cmd  = cmd_req && !eng_busy && illegal;

        req.bank = reg_wdata[1:0];
        if (ctrl_raw) begin
            req.tx_bytes = {1'b0, reg_wdata[5:4]} + 3'd1;
            req.rx_bytes = reg_wdata[7:6];
            req.tx_word  = tx_reg;
        end else begin
            req.tx_bytes = 3'd1;
            req.rx_bytes = f_rd ? 2'd1 : 2'd0;
            req.tx_word  = {24'd0, (f_rd ? OP_RDSR : OP_WREN)};
        end
    end

    sfc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy),
        .half_div(ctrl_div), .half_tick(half_tick)
    );

    sfc_engine #(.NUM_BANKS(NUM_BANKS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req),
        .half_tick(half_tick), .spi_miso(spi_miso),
        .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    // register file and status tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_raw      <= 1'b0;
            ctrl_div      <= DIV_W'(DIV_RESET);
            tx_reg        <= '0;
            rx_reg        <= '0;
            flag_done     <= 1'b0;
            flag_err_busy <= 1'b0;
            flag_err_cmd  <= 1'b0;
            flag_wcf      <= 1'b0;
            we_copy       <= '0;
            stat_byte     <= '0;
            op_kind       <= OPK_RAW;
            op_bank       <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_CTRL) begin
                ctrl_raw <= reg_wdata[0];
                ctrl_div <= reg_wdata[DIV_LSB +: DIV_W];
            end
            if (reg_wr && reg_addr == ADDR_TXD) tx_reg <= reg_wdata;
            if (start) begin
                op_bank <= req.bank;
                op_kind <= ctrl_raw ? OPK_RAW : (f_rd ? OPK_RDSR : OPK_WREN);
            end
            flag_done     <= eng_done    || (flag_done     && !(stat_wr && !reg_wdata[0]));
            flag_err_busy <= reject_busy || (flag_err_busy && !(stat_wr && !reg_wdata[1]));
            flag_err_cmd  <= reject_cmd  || (flag_err_cmd  && !(stat_wr && !reg_wdata[2]));
            flag_wcf      <= (eng_done && op_kind == OPK_RDSR && !eng_rx[16])
                             || (flag_wcf && !(stat_wr && !reg_wdata[3]));
            if (eng_done) begin
                rx_reg <= eng_rx;
                if (op_kind == OPK_RDSR) begin
                    stat_byte        <= eng_rx[23:16];
                    we_copy[op_bank] <= eng_rx[17];
                end else if (op_kind == OPK_WREN) begin
                    we_copy[op_bank] <= 1'b1;
                end
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[0]               = ctrl_raw;
                reg_rdata[DIV_LSB +: DIV_W] = ctrl_div;
            end
            ADDR_TXD: reg_rdata = tx_reg;
            ADDR_RXD: reg_rdata = {8'd0, rx_reg};
            ADDR_STAT: begin
                reg_rdata[0]     = flag_done;
                reg_rdata[1]     = flag_err_busy;
                reg_rdata[2]     = flag_err_cmd;
                reg_rdata[3]     = flag_wcf;
                reg_rdata[31:24] = stat_byte;
                for (int i = 0; i < NUM_BANKS; i++)
                    reg_rdata[WE_SHIFT + i] = we_copy[i];
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] spi_cs_n,
    input logic                 spi_sclk,
    input logic                 eng_busy,
    input logic                 cmd_req,
    input logic                 flag_err_busy,
    input logic                 flag_done,
    input logic                 stat_wr
);
    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    assert_cs_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&spi_cs_n)) |-> eng_busy);

    assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sclk);

    assert_cs_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> $stable(spi_cs_n));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && !stat_wr) |=> flag_done);

    assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && cmd_req) |=> flag_err_busy);
endmodule

bind serial_flash_ctrl sfc_checker #(.NUM_BANKS(NUM_BANKS)) u_sfc_checker (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .eng_busy(eng_busy), .cmd_req(cmd_req), .flag_err_busy(flag_err_busy),
    .flag_done(flag_done), .stat_wr(stat_wr)
);

// File: tb/tb_serial_flash_ctrl.sv
`timescale 1ns/1ps
module tb_serial_flash_ctrl;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          spi_sclk, spi_mosi, spi_miso;
    logic [NB-1:0] spi_cs_n;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    serial_flash_ctrl #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // ---------------- flash responder ----------------
    logic [NB-1:0] wel = '0;
    logic [NB-1:0] wip = '0;
    logic [7:0]    r_bytes [0:7];
    logic [7:0]    r_cur = '0;
    int  r_bits = 0, r_bank = 0, r_nlow = 0, r_count = 0;
    time r_last_rise = 0, r_last_fall = 0, r_period = 0, r_hold = 0;
    wire cs_act = ~&spi_cs_n;

    function automatic logic [7:0] reply(input logic [7:0] op, input int pos, input int bank);
        if (op == 8'h9F)      return (pos == 1) ? 8'(8'h14 + bank) : 8'h20;
        else if (op == 8'h05) return {6'd0, wel[bank], wip[bank]};
        else                  return 8'(op ^ 8'(17 * pos) ^ 8'(bank));
    endfunction

    always @(posedge cs_act) begin
        r_bits = 0;
        r_nlow = $countones(~spi_cs_n);
        for (int i = 0; i < NB; i++) if (!spi_cs_n[i]) r_bank = i;
    end

    always @(negedge cs_act) begin
        r_count = r_count + 1;
        r_hold  = $time - r_last_fall;
        if (r_bits == 8 && r_bytes[0] == 8'h06) wel[r_bank] = 1'b1;
        if (r_bits == 8 && r_bytes[0] == 8'h04) wel[r_bank] = 1'b0;
    end

    always @(posedge spi_sclk) begin
        if (cs_act) begin
            if (r_bits > 0) r_period = $time - r_last_rise;
            r_last_rise = $time;
            r_cur  = {r_cur[6:0], spi_mosi};
            r_bits = r_bits + 1;
            if (r_bits % 8 == 0 && r_bits <= 64) r_bytes[r_bits/8 - 1] = r_cur;
        end
    end

    always @(negedge spi_sclk) r_last_fall = $time;

    always_comb begin
        logic [7:0] rb;
        if (r_bits / 8 == 0) spi_miso = 1'b0;
        else begin
            rb = reply(r_bytes[0], r_bits / 8, r_bank);
            spi_miso = rb[7 - (r_bits % 8)];
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 4000; i++) begin
            rd(3'd4, s);
            if (s[0]) break;
        end
        check({tag, " done"}, {31'd0, s[0]}, 32'd1);
    endtask

    initial begin
        #(8ns * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v, txw, exp;
        logic [7:0]  op;
        int c0;
        v = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'h20);
        rd(3'd4, v); check("R1 status", v, 32'h0);
        rd(3'd3, v); check("R1 rx", v, 32'h0);
        check("R1 cs", {28'd0, spi_cs_n}, 32'hF);
        check("R1 sclk", {31'd0, spi_sclk}, 32'd0);

        // raw-mode sweep: banks x tx lengths x rx lengths (R2 R3 R4)
        wr(3'd0, 32'h21);
        for (int b = 0; b < NB; b++)
            for (int tl = 1; tl <= 4; tl++)
                for (int rl = 0; rl <= 3; rl++) begin
                    for (int i = 0; i < 4; i++)
                        txw[8*i +: 8] = 8'(8'h30 + 16*b + 4*(tl-1) + i);
                    op = txw[8*(tl-1) +: 8];
                    wr(3'd2, txw);
                    wr(3'd1, 32'(b | (1 << 2) | ((tl-1) << 4) | (rl << 6)));
                    wait_done("R5 sweep");
                    exp = '0;
                    for (int j = 0; j < rl; j++)
                        exp[23 - 8*j -: 8] = reply(op, tl + j, b);
                    rd(3'd3, v); check("R4 rx word", v, exp);
                    check("R3 byte count", 32'(r_bits / 8), 32'(tl + rl));
                    v = 32'd1;
                    for (int k = 0; k < tl; k++)
                        if (r_bytes[k] !== txw[8*(tl-1-k) +: 8]) v = 32'd0;
                    check("R3 tx bytes msb first", v, 32'd1);
                    check("R2 bank", 32'(r_bank), 32'(b));
                    check("R2 single cs", 32'(r_nlow), 32'd1);
                    if (b == 3 && tl == 4 && rl == 3) begin
                        check("R10 period N=2", 32'(r_period), 32'd32);
                        check("R11 hold N=2", 32'(r_hold), 32'd32);
                        repeat (20) @(negedge clk);
                        rd(3'd4, v); check("R5 still set", {31'd0, v[0]}, 32'd1);
                        wr(3'd4, 32'hFFFF_FFFF);
                        rd(3'd4, v); check("R5 write 1 keeps", {31'd0, v[0]}, 32'd1);
                    end
                    wr(3'd4, 32'h0);
                    rd(3'd4, v); check("R5 cleared", {31'd0, v[0]}, 32'd0);
                end

        // identification read (R4)
        wr(3'd2, 32'h9F);
        wr(3'd1, 32'(3 | (1 << 2) | (3 << 6)));
        wait_done("R4 id");
        rd(3'd3, v); check("R4 id word", v, 32'h0017_2020);
        wr(3'd4, 32'h0);

        // prescaler N=3 and N=0 (R10 R11)
        wr(3'd0, 32'h31);
        wr(3'd2, 32'h5A);
        wr(3'd1, 32'(1 | (1 << 2) | (1 << 6)));
        wait_done("R10 n3");
        check("R10 period N=3", 32'(r_period), 32'd48);
        check("R11 hold N=3", 32'(r_hold), 32'd48);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h01);
        wr(3'd1, 32'(2 | (1 << 2)));
        wait_done("R10 n0");
        check("R10 period N=0", 32'(r_period), 32'd16);
        check("R11 hold N=0", 32'(r_hold), 32'd16);
        wr(3'd4, 32'h0);

        // start while busy (R8)
        wr(3'd0, 32'h31);
        c0 = r_count;
        wr(3'd2, 32'h4142_4344);
        wr(3'd1, 32'(0 | (1 << 2) | (3 << 4) | (3 << 6)));
        wr(3'd1, 32'(3 | (1 << 2)));
        rd(3'd4, v); check("R8 busy error", {31'd0, v[1]}, 32'd1);
        wait_done("R8");
        repeat (60) @(negedge clk);
        check("R8 one transfer", 32'(r_count - c0), 32'd1);
        check("R8 bank kept", 32'(r_bank), 32'd0);
        check("R8 length kept", 32'(r_bits / 8), 32'd7);
        wr(3'd4, 32'h0);

        // illegal commands (R9)
        wr(3'd0, 32'h21);
        c0 = r_count;
        wr(3'd1, 32'(1 << 8));
        rd(3'd4, v); check("R9 raw hw bit", v[2:0], 3'b100);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h20);
        wr(3'd1, 32'(1 << 2));
        rd(3'd4, v); check("R9 fixed send", v[2:0], 3'b100);
        wr(3'd4, 32'h0);
        wr(3'd1, 32'(3 << 8));
        rd(3'd4, v); check("R9 both fixed", v[2:0], 3'b100);
        repeat (60) @(negedge clk);
        check("R9 no transfer", 32'(r_count - c0), 32'd0);
        wr(3'd4, 32'h0);

        // fixed-command mode (R6 R7)
        wip[1] = 1'b1;
        wr(3'd1, 32'(1 | (1 << 8)));
        wait_done("R6 rdsr busy");
        rd(3'd4, v);
        check("R6 status byte", {24'd0, v[31:24]}, 32'h01);
        check("R6 wcf clear while wip", {31'd0, v[3]}, 32'd0);
        check("R7 we clear", {31'd0, v[9]}, 32'd0);
        check("R6 opcode", {24'd0, r_bytes[0]}, 32'h05);
        check("R6 length", 32'(r_bits / 8), 32'd2);
        wr(3'd4, 32'h0);
        wr(3'd1, 32'(1 | (1 << 9)));
        wait_done("R7 wren");
        check("R7 opcode", {24'd0, r_bytes[0]}, 32'h06);
        check("R7 length", 32'(r_bits / 8), 32'd1);
        rd(3'd4, v); check("R7 we bank1", {28'd0, v[11:8]}, 32'h2);
        wr(3'd4, 32'h0);
        wip[1] = 1'b0;
        wr(3'd1, 32'(1 | (1 << 8)));
        wait_done("R6 rdsr idle");
        rd(3'd4, v);
        check("R6 status byte idle", {24'd0, v[31:24]}, 32'h02);
        check("R6 wcf set", {31'd0, v[3]}, 32'd1);
        wr(3'd4, 32'hFFFF_FFFE);
        rd(3'd4, v);
        check("R5 done cleared alone", {31'd0, v[0]}, 32'd0);
        check("R6 wcf kept by 1", {31'd0, v[3]}, 32'd1);
        wr(3'd4, 32'h0);
        rd(3'd4, v); check("R6 wcf cleared", {31'd0, v[3]}, 32'd0);

        // latch cleared on the flash, mirrored by a fetch (R7)
        wr(3'd0, 32'h21);
        wr(3'd2, 32'h04);
        wr(3'd1, 32'(1 | (1 << 2)));
        wait_done("R7 wrdi");
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h20);
        wr(3'd1, 32'(1 | (1 << 8)));
        wait_done("R7 refresh");
        rd(3'd4, v); check("R7 we mirrored clear", {28'd0, v[11:8]}, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd1, 32'(2 | (1 << 9)));
        wait_done("R7 wren bank2");
        rd(3'd4, v); check("R7 we bank2 only", {28'd0, v[11:8]}, 32'h4);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule